// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control unit of a small accumulator CPU with 8-bit data. It runs three multi-cycle sequences. The first is hardware interrupt entry. The second is the software interrupt instruction, which carries an 8-bit code in its immediate byte. The third is the interrupt-return instruction. The main pipeline presents the opcode and its immediate at every instruction boundary. It also supplies the current program counter (the address of that opcode), the accumulator and the flags. The block answers with `busy` for the length of the sequence. In the last cycle it raises `done` together with write strobes for the program counter, accumulator and flags.

On entry, three values are copied into private shadow registers: the return address, the accumulator and the flags. The accumulator then receives the interrupt code, the program counter receives the fixed vector, and the interrupt-enable bit is cleared. Return writes the three shadow values back and sets interrupt-enable. There is only one shadow set, so interrupts cannot nest. After reset the block runs a one-cycle boot sequence that loads code 0 and the same vector. Handler code can therefore tell a cold start from an interrupt.

States: `ST_BOOT` (reset and the first cycle after it), `ST_IDLE` (waiting at an instruction boundary), `ST_HW` (hardware entry), `ST_SW` (software interrupt) and `ST_RET` (return). Transitions:
- `ST_BOOT` goes to `ST_IDLE`.
- `ST_IDLE` goes to `ST_SW`, `ST_HW` or `ST_RET` when the arbiter picks a request.
- Each of the three sequence states counts down and goes to `ST_IDLE` after its last cycle.
- Reset leads to `ST_BOOT` from any state.

Top module: `irq_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy` and `done` are 1, `pc_we` writes `VECTOR`, `acc_we` writes 0, and `ie` is 0. In the following cycle `busy` is 0.
- R2: In an idle cycle, `instr_valid`=1 with `opcode`=0x21 (software interrupt) is accepted. It gives exactly `SW_CYC` (7) busy cycles. The last of them has `done`=1, `pc_wdata`=`VECTOR`, `acc_wdata` equal to the `imm` sampled at acceptance, and `flags_we`=0.
- R3: In an idle cycle, `opcode`=0x29 (interrupt return) that is not preempted gives exactly `RET_CYC` (4) busy cycles. The last cycle writes PC, accumulator and flags from the shadow registers. `ie` reads 1 from the cycle after `done`.
- R4: A hardware interrupt is accepted when `instr_valid`=1, the block is idle, `hw_req`=1, `ie`=1 and `opcode`≠0x21. It gives exactly `HW_CYC` (8) busy cycles. The last cycle writes `VECTOR` to the PC and the `hw_code` sampled at acceptance to the accumulator.
- R5: Hardware entry saves `pc_in` as the return address. Software entry saves `pc_in`+2, wrapping at `AW` bits.
- R6: Both kinds of entry clear `ie` from the cycle after acceptance, and `ie` stays 0 through the sequence.
- R7: While `ie`=0, `hw_req` is ignored. A software interrupt is still accepted.
- R8: When a software interrupt and an enabled hardware request arrive in the same cycle, the software interrupt is taken. A hardware request preempts any other opcode, including return.
- R9: Shadow registers change only on entry. A second return replays the same values, and a second entry without a return in between overwrites the first.
- R10: `done` is high for exactly one cycle, the last one of each sequence. Write strobes are asserted only while `done` is 1.
- R11: `ie_we` loads `ie_wdata` into `ie` only in an idle cycle that starts no sequence. It has no effect while `busy`=1.
- R12: Without `instr_valid`, or when `instr_valid`=1 carries a different opcode and no enabled hardware request, no sequence starts and no write strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction boundary: opcode, immediate and PC are valid |
| opcode | input | 8 | Opcode byte at the boundary |
| imm | input | 8 | Immediate byte following the opcode |
| hw_req | input | 1 | Hardware interrupt request, level |
| hw_code | input | 8 | Code of the hardware request |
| ie_we | input | 1 | Pipeline write of the interrupt-enable bit |
| ie_wdata | input | 1 | Value for `ie_we` |
| pc_in | input | AW | Address of the opcode presented |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | FW | Current flags |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |
| ie | output | 1 | Interrupt-enable bit |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | AW | Program counter write value |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | Accumulator write value |
| flags_we | output | 1 | Flags write strobe |
| flags_wdata | output | FW | Flags write value |

## Verification
The bench builds the block with `AW`=12, `FW`=4 and `VECTOR`=0xA50. The cycle counts keep their defaults of 8, 7 and 4.

The narrow address lets a software interrupt at address 0xFFF check the wrap of the saved return address. The non-zero vector, which is not aligned to any field, makes a wrongly routed PC source show up at once. The 4-bit flags keep the restored flag patterns easy to tell apart from accumulator values.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam logic [7:0] OP_SWI  = 8'b0010_0001;
    localparam logic [7:0] OP_IRET = 8'b0010_1001;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_HW,
        ST_SW,
        ST_RET
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_HW,
        REQ_SW,
        REQ_RET
    } req_kind_e;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic       instr_valid,
    input  logic       idle,
    input  logic [7:0] opcode,
    input  logic       hw_req,
    input  logic       ie,
    output req_kind_e  kind
);

    always_comb begin
        kind = REQ_NONE;
        if (instr_valid && idle) begin
            if (opcode == OP_SWI) begin
                kind = REQ_SW;
            end else if (hw_req && ie) begin
                kind = REQ_HW;
            end else if (opcode == OP_IRET) begin
                kind = REQ_RET;
            end
        end
    end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
#(
    parameter int HW_CYC  = 8,
    parameter int SW_CYC  = 7,
    parameter int RET_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  req_kind_e  kind,
    output seq_state_e state,
    output logic       last
);

    localparam int MAXC = (HW_CYC > SW_CYC) ?
                          ((HW_CYC > RET_CYC) ? HW_CYC : RET_CYC) :
                          ((SW_CYC > RET_CYC) ? SW_CYC : RET_CYC);
    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_BOOT: begin
                    state <= ST_IDLE;
                end
                ST_IDLE: begin
                    unique case (kind)
                        REQ_HW: begin
                            state <= ST_HW;
                            cnt   <= CW'(HW_CYC - 1);
                        end
                        REQ_SW: begin
                            state <= ST_SW;
                            cnt   <= CW'(SW_CYC - 1);
                        end
                        REQ_RET: begin
                            state <= ST_RET;
                            cnt   <= CW'(RET_CYC - 1);
                        end
                        default: ;
                    endcase
                end
                ST_HW, ST_SW, ST_RET: begin
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign last = (state != ST_IDLE) && (cnt == '0);

endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
    parameter int AW = 16,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] cap_pc,
    input  logic [7:0]    cap_acc,
    input  logic [FW-1:0] cap_flags,
    output logic [AW-1:0] sh_pc,
    output logic [7:0]    sh_acc,
    output logic [FW-1:0] sh_flags
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_pc    <= '0;
            sh_acc   <= '0;
            sh_flags <= '0;
        end else if (capture) begin
            sh_pc    <= cap_pc;
            sh_acc   <= cap_acc;
            sh_flags <= cap_flags;
        end
    end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_pkg::*;
#(
    parameter int            AW      = 16,
    parameter int            FW      = 8,
    parameter logic [AW-1:0] VECTOR  = '0,
    parameter int            HW_CYC  = 8,
    parameter int            SW_CYC  = 7,
    parameter int            RET_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [7:0]    opcode,
    input  logic [7:0]    imm,
    input  logic          hw_req,
    input  logic [7:0]    hw_code,
    input  logic          ie_we,
    input  logic          ie_wdata,
    input  logic [AW-1:0] pc_in,
    input  logic [7:0]    acc_in,
    input  logic [FW-1:0] flags_in,
    output logic          busy,
    output logic          done,
    output logic          ie,
    output logic          pc_we,
    output logic [AW-1:0] pc_wdata,
    output logic          acc_we,
    output logic [7:0]    acc_wdata,
    output logic          flags_we,
    output logic [FW-1:0] flags_wdata
);

    seq_state_e    state;
    req_kind_e     kind;
    logic          last;
    logic          entry;
    logic [AW-1:0] ret_addr;
    logic [AW-1:0] sh_pc;
    logic [7:0]    sh_acc;
    logic [FW-1:0] sh_flags;
    logic [7:0]    code_q;

    irq_arbiter u_arb (
        .instr_valid (instr_valid),
        .idle        (state == ST_IDLE),
        .opcode      (opcode),
        .hw_req      (hw_req),
        .ie          (ie),
        .kind        (kind)
    );

    irq_seq_fsm #(
        .HW_CYC  (HW_CYC),
        .SW_CYC  (SW_CYC),
        .RET_CYC (RET_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .state (state),
        .last  (last)
    );

    assign entry    = (kind == REQ_HW) || (kind == REQ_SW);
    assign ret_addr = (kind == REQ_HW) ? pc_in : pc_in + AW'(2);

    irq_shadow #(
        .AW (AW),
        .FW (FW)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (entry),
        .cap_pc    (ret_addr),
        .cap_acc   (acc_in),
        .cap_flags (flags_in),
        .sh_pc     (sh_pc),
        .sh_acc    (sh_acc),
        .sh_flags  (sh_flags)
    );

    // Interrupt code and enable bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            ie     <= 1'b0;
        end else begin
            if (kind == REQ_HW) begin
                code_q <= hw_code;
            end else if (kind == REQ_SW) begin
                code_q <= imm;
            end
            if (entry) begin
                ie <= 1'b0;
            end else if (state == ST_RET && last) begin
                ie <= 1'b1;
            end else if (state == ST_IDLE && kind == REQ_NONE && ie_we) begin
                ie <= ie_wdata;
            end
        end
    end

    // Output decode per state.
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = last;
        pc_we       = 1'b0;
        pc_wdata    = VECTOR;
        acc_we      = 1'b0;
        acc_wdata   = code_q;
        flags_we    = 1'b0;
        flags_wdata = sh_flags;
        unique case (state)
            ST_BOOT: begin
                pc_we     = 1'b1;
                acc_we    = 1'b1;
                acc_wdata = 8'h00;
            end
            ST_HW, ST_SW: begin
                pc_we  = last;
                acc_we = last;
            end
            ST_RET: begin
                pc_we     = last;
                pc_wdata  = sh_pc;
                acc_we    = last;
                acc_wdata = sh_acc;
                flags_we  = last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker
    import irq_pkg::*;
#(
    parameter int HW_CYC  = 8,
    parameter int SW_CYC  = 7,
    parameter int RET_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_valid,
    input logic [7:0] opcode,
    input logic       hw_req,
    input logic       ie,
    input logic       busy,
    input logic       done,
    input logic       pc_we,
    input logic       acc_we,
    input logic       flags_we
);

    logic [7:0] exp_len;
    logic [7:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_len <= 8'd1;
            run_cnt <= 8'd0;
        end else begin
            if (!busy && instr_valid) begin
                if (opcode == OP_SWI)       exp_len <= 8'(SW_CYC);
                else if (hw_req && ie)      exp_len <= 8'(HW_CYC);
                else if (opcode == OP_IRET) exp_len <= 8'(RET_CYC);
                else                        exp_len <= 8'd0;
            end
            if (busy && !done) run_cnt <= run_cnt + 8'd1;
            else               run_cnt <= 8'd0;
        end
    end

    AST_SEQ_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt + 8'd1 == exp_len)); // R2

    AST_DONE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10

    AST_WRITE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we || acc_we || flags_we) |-> done); // R10

    AST_RET_WRITES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (pc_we && acc_we)); // R3

    AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy && opcode == OP_SWI) |=> !ie); // R6

    AST_HW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !busy && !ie && opcode != OP_SWI && opcode != OP_IRET) |=> !busy); // R7

    AST_IE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(ie)); // R11

endmodule

bind irq_sequencer irq_seq_checker #(
    .HW_CYC  (HW_CYC),
    .SW_CYC  (SW_CYC),
    .RET_CYC (RET_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .hw_req      (hw_req),
    .ie          (ie),
    .busy        (busy),
    .done        (done),
    .pc_we       (pc_we),
    .acc_we      (acc_we),
    .flags_we    (flags_we)
);

// File: tb/irq_sequencer_test.sv
module irq_sequencer_test;

    localparam int          AW  = 12;
    localparam int          FW  = 4;
    localparam logic [11:0] VEC = 12'hA50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [7:0]    opcode = '0;
    logic [7:0]    imm = '0;
    logic          hw_req = 1'b0;
    logic [7:0]    hw_code = '0;
    logic          ie_we = 1'b0;
    logic          ie_wdata = 1'b0;
    logic [AW-1:0] pc_in = '0;
    logic [7:0]    acc_in = '0;
    logic [FW-1:0] flags_in = '0;
    logic          busy, done, ie, pc_we, acc_we, flags_we;
    logic [AW-1:0] pc_wdata;
    logic [7:0]    acc_wdata;
    logic [FW-1:0] flags_wdata;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_sequencer #(
        .AW (AW), .FW (FW), .VECTOR (VEC),
        .HW_CYC (8), .SW_CYC (7), .RET_CYC (4)
    ) uut (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid),
        .opcode (opcode), .imm (imm), .hw_req (hw_req), .hw_code (hw_code),
        .ie_we (ie_we), .ie_wdata (ie_wdata), .pc_in (pc_in),
        .acc_in (acc_in), .flags_in (flags_in), .busy (busy), .done (done),
        .ie (ie), .pc_we (pc_we), .pc_wdata (pc_wdata), .acc_we (acc_we),
        .acc_wdata (acc_wdata), .flags_we (flags_we), .flags_wdata (flags_wdata)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // kind: 0 none, 1 hardware, 2 software, 3 return
    typedef struct packed {
        logic [7:0]  opc;
        logic [7:0]  imm;
        logic        hw;
        logic [7:0]  code;
        logic        ie_pre;
        logic [11:0] pc;
        logic [7:0]  acc;
        logic [3:0]  fl;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h21, 8'h42, 1'b0, 8'h00, 1'b0, 12'h100, 8'h11, 4'h3, 2'd2},
        '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 12'h555, 8'hEE, 4'hE, 2'd3},
        '{8'h07, 8'h00, 1'b1, 8'h5A, 1'b1, 12'h200, 8'h22, 4'h5, 2'd1},
        '{8'h29, 8'h00, 1'b1, 8'h77, 1'b0, 12'h666, 8'hDD, 4'hD, 2'd3},
        '{8'h21, 8'h09, 1'b1, 8'h33, 1'b1, 12'h300, 8'h44, 4'hA, 2'd2},
        '{8'h05, 8'h00, 1'b1, 8'h66, 1'b0, 12'h777, 8'hCC, 4'hC, 2'd0},
        '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 12'h888, 8'hBB, 4'hB, 2'd3},
        '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 12'h999, 8'hAA, 4'h9, 2'd3},
        '{8'h21, 8'h10, 1'b0, 8'h00, 1'b0, 12'hFFF, 8'h66, 4'hF, 2'd2},
        '{8'h21, 8'h20, 1'b0, 8'h00, 1'b0, 12'h400, 8'h77, 4'h1, 2'd2},
        '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 12'hABC, 8'h99, 4'h8, 2'd3},
        '{8'h29, 8'h00, 1'b1, 8'h3C, 1'b1, 12'h500, 8'h12, 4'h2, 2'd1},
        '{8'h29, 8'h00, 1'b0, 8'h00, 1'b0, 12'h123, 8'h45, 4'h6, 2'd3}
    };

    // Captured per sequence
    int          m_len, m_dones;
    logic        m_pcwe, m_accwe, m_flwe, m_ie_first, m_ie_after;
    logic [11:0] m_pc;
    logic [7:0]  m_acc;
    logic [3:0]  m_fl;

    task automatic present(input logic [7:0] o, input logic [7:0] im, input logic h,
                           input logic [7:0] c, input logic [11:0] p,
                           input logic [7:0] a, input logic [3:0] f);
        @(negedge clk);
        instr_valid = 1'b1; opcode = o; imm = im; hw_req = h; hw_code = c;
        pc_in = p; acc_in = a; flags_in = f;
        @(negedge clk);
        instr_valid = 1'b0; hw_req = 1'b0; opcode = 8'h00; imm = 8'hFF;
        hw_code = 8'hFF; pc_in = '1; acc_in = 8'hFF; flags_in = '1;
        #1;
        m_len = 0; m_dones = 0; m_pcwe = 0; m_accwe = 0; m_flwe = 0;
        m_ie_first = ie;
        while (busy && m_len < 20) begin
            if (done) begin
                m_dones++;
                m_pcwe = pc_we; m_accwe = acc_we; m_flwe = flags_we;
                m_pc = pc_wdata; m_acc = acc_wdata; m_fl = flags_wdata;
            end else if (pc_we || acc_we || flags_we) begin
                m_dones += 100;
            end
            m_len++;
            @(negedge clk); #1;
        end
        m_ie_after = ie;
    endtask

    task automatic set_ie(input logic v);
        @(negedge clk);
        ie_we = 1'b1; ie_wdata = v;
        @(negedge clk);
        ie_we = 1'b0; ie_wdata = 1'b0;
        #1;
        chk("R11 ie_we at idle", int'(ie), int'(v));
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] sh_pc;
        logic [7:0]  sh_acc;
        logic [3:0]  sh_fl;
        sh_pc = '0; sh_acc = '0; sh_fl = '0;

        // R1 boot
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 boot busy", int'(busy), 1);
        chk("R1 boot done", int'(done), 1);
        chk("R1 boot pc", int'(pc_we ? pc_wdata : 12'h000), int'(VEC));
        chk("R1 boot acc", int'(acc_we ? acc_wdata : 8'hFF), 0);
        chk("R1 boot ie", int'(ie), 0);
        @(negedge clk); #1;
        chk("R1 boot ends", int'(busy), 0);

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   el;
            v = VECS[i];
            set_ie(v.ie_pre);
            present(v.opc, v.imm, v.hw, v.code, v.pc, v.acc, v.fl);
            el = (v.kind == 2'd1) ? 8 : (v.kind == 2'd2) ? 7 : (v.kind == 2'd3) ? 4 : 0;
            case (v.kind)
                2'd0: begin
                    chk("R12 no sequence", m_len, 0);
                    chk("R7 masked ie unchanged", int'(m_ie_after), int'(v.ie_pre));
                end
                2'd1: begin
                    chk("R4 hw length", m_len, el);
                    chk("R10 single done", m_dones, 1);
                    chk("R4 hw pc", int'(m_pc), int'(VEC));
                    chk("R4 hw acc code", int'(m_acc), int'(v.code));
                    chk("R8 hw no flags write", int'(m_flwe), 0);
                    chk("R6 ie cleared", int'(m_ie_first), 0);
                    sh_pc = v.pc; sh_acc = v.acc; sh_fl = v.fl;
                end
                2'd2: begin
                    chk("R2 sw length", m_len, el);
                    chk("R10 single done", m_dones, 1);
                    chk("R2 sw pc", int'(m_pcwe ? m_pc : 12'h000), int'(VEC));
                    chk("R2 sw acc imm", int'(m_accwe ? m_acc : 8'h00), int'(v.imm));
                    chk("R2 sw no flags write", int'(m_flwe), 0);
                    chk("R6 ie cleared", int'(m_ie_first), 0);
                    chk("R7 ie stays clear", int'(m_ie_after), 0);
                    sh_pc = v.pc + 12'd2; sh_acc = v.acc; sh_fl = v.fl;
                end
                default: begin
                    chk("R3 ret length", m_len, el);
                    chk("R10 single done", m_dones, 1);
                    chk("R5 ret pc", int'(m_pc), int'(sh_pc));
                    chk("R9 ret acc", int'(m_acc), int'(sh_acc));
                    chk("R3 ret flags", int'(m_flwe ? m_fl : 4'h0), int'(sh_fl));
                    chk("R3 ie set", int'(m_ie_after), 1);
                end
            endcase
        end

        // R11: ie_we ignored while busy
        set_ie(1'b0);
        @(negedge clk);
        instr_valid = 1'b1; opcode = 8'h21; imm = 8'h01; pc_in = 12'h010;
        @(negedge clk);
        instr_valid = 1'b0; opcode = 8'h00;
        ie_we = 1'b1; ie_wdata = 1'b1;
        @(negedge clk);
        ie_we = 1'b0; ie_wdata = 1'b0;
        repeat (8) @(negedge clk);
        #1;
        chk("R11 ie_we ignored busy", int'(ie), 0);
        chk("R11 sequence over", int'(busy), 0);

        // R12: request without boundary
        set_ie(1'b1);
        @(negedge clk);
        hw_req = 1'b1; hw_code = 8'h55; instr_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R12 no boundary no entry", int'(busy), 0);
        chk("R12 ie kept", int'(ie), 1);
        hw_req = 1'b0;

        // R1: reset in the middle of a sequence
        @(negedge clk);
        instr_valid = 1'b1; opcode = 8'h21; imm = 8'h7E;
        @(negedge clk);
        instr_valid = 1'b0; opcode = 8'h00;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reboot done", int'(done), 1);
        chk("R1 reboot pc", int'(pc_wdata), int'(VEC));
        chk("R1 reboot acc", int'(acc_wdata), 0);
        chk("R1 reboot ie", int'(ie), 0);
        @(negedge clk); #1;
        chk("R1 reboot idle", int'(busy), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule